// File: doc/BRIEF.md
# Frame Sync Pulse Generator

This block produces the 8 kHz frame synchronisation pulse for a 2.048 MHz serial time-division bus from a bit clock that is already locked to the network. The bit clock is handed straight through as the bus data clock. A counter divides it by 256, and the most significant counter bit is a square wave with equal high and low halves. That wave is narrowed into a pulse exactly one bit period wide. The narrowing stage is a pair of flip-flops clocked on the falling edge of the bit clock. The result meets the bus rule that frame sync lasts between one and eight data-clock periods.

A second output, the frame-start strobe, carries the same event into the rising-edge domain. It is one cycle long and lets slot counters that run on the rising edge realign at the start of each frame. The reset is synchronous and active low. While it is held, the divider returns to zero and both pulse outputs go quiet. The first pulse after release comes when the divided wave first rises.

Top module: `fsync_gen`

## Requirements
- R1: `dclk_o` always carries the same level as `bclk_i`.
- R2: When `rst_n_i` is released, count the rising edges of `bclk_i` that sample it high as 1, 2, 3 and so on. Up to the falling edge that follows rising edge 128, `fsync_o` and `frame_start_o` stay low. `fsync_o` first goes high at that falling edge.
- R3: Each `fsync_o` pulse goes high at a falling edge of `bclk_i` and goes low at the next falling edge, so it is exactly one bit-clock period wide.
- R4: With the divide ratio at its default of 256, a new `fsync_o` pulse begins every 256 bit-clock periods. Pulses begin at the falling edges after rising edges 128, 384, 640 and so on.
- R5: `frame_start_o` goes high at the first rising edge of `bclk_i` that falls inside an `fsync_o` pulse, i.e. rising edge 129, 385, 641 and so on. It stays high for exactly one bit-clock period.
- R6: Pulling `rst_n_i` low in the middle of operation forces `frame_start_o` low from the next rising edge, and `fsync_o` low from the next falling edge. Both stay low while reset is held. After release, the phase restarts exactly as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Network-locked 2.048 MHz bit clock |
| rst_n_i | input | 1 | Synchronous reset, active low, sampled on both clock edges |
| dclk_o | output | 1 | Bus data clock, the bit clock passed through |
| fsync_o | output | 1 | One-period frame sync pulse, changes on falling edges |
| frame_start_o | output | 1 | One-cycle frame-start strobe, changes on rising edges |

## Verification
The assertions assume that `bclk_i` is a free-running clock with no missing or extra edges. They also assume that `rst_n_i` changes away from both clock edges. Under those assumptions, the counter advances by exactly one per rising edge, and the pulse spacing checked in the top module is exact. The stimulus meets these assumptions: it drives a steady clock, and it moves reset only just after a falling edge. A mid-run reset is placed so that the restart of the divider phase, and the quiet interval, are both exercised.

// File: rtl/fsync_pkg.sv
// Shared constants for the frame sync generator.
// Assumes a power-of-two divide ratio between bit clock and frame rate.
package fsync_pkg;
    // Default counter width: 2**8 = 256 bit clocks per frame.
    localparam int unsigned DEF_DIV_W = 8;
endpackage

// File: rtl/fsync_div.sv
// Free-running bit-clock divider. Its most significant bit is a square
// wave at 1/2**DIV_W of the bit clock, high for the second half of each count.
// Assumes a clean clock; reset is synchronous and active low.
module fsync_div #(
    parameter int unsigned DIV_W = fsync_pkg::DEF_DIV_W
) (
    input  logic bclk_i,
    input  logic rst_n_i,
    output logic sq_o
);
    logic [DIV_W-1:0] cnt_q;

    // Advance the divider by one every rising edge.
    always_ff @(posedge bclk_i) begin
        if (!rst_n_i) cnt_q <= '0;
        else          cnt_q <= cnt_q + 1'b1;
    end

    assign sq_o = cnt_q[DIV_W-1];

    // R4
    div_step_chk: assert property (@(posedge bclk_i) disable iff (!rst_n_i)
        $past(rst_n_i) |-> cnt_q == DIV_W'($past(cnt_q) + 1'b1));
endmodule

// File: rtl/fsync_shaper.sv
// Narrows the divided square wave to a one-bit-period pulse. Two cascaded
// flops sample the wave on the falling edge; the pulse is the first flop
// high while the second is still low. Assumes the input changes only on
// rising edges.
module fsync_shaper (
    input  logic bclk_i,
    input  logic rst_n_i,
    input  logic sq_i,
    output logic pulse_o
);
    logic st1_q;
    logic st2_q;

    // Two-stage shift of the square wave on the falling edge.
    always_ff @(negedge bclk_i) begin
        if (!rst_n_i) begin
            st1_q <= 1'b0;
            st2_q <= 1'b0;
        end else begin
            st1_q <= sq_i;
            st2_q <= st1_q;
        end
    end

    assign pulse_o = st1_q & ~st2_q;

    // R3
    one_period_chk: assert property (@(negedge bclk_i) disable iff (!rst_n_i)
        pulse_o |=> !pulse_o);
endmodule

// File: rtl/fsync_strobe.sv
// Retimes the frame sync pulse into the rising-edge domain as a
// one-cycle frame-start strobe. Assumes the pulse lasts one period.
module fsync_strobe (
    input  logic bclk_i,
    input  logic rst_n_i,
    input  logic pulse_i,
    output logic strobe_o
);
    // Capture the falling-edge pulse at the next rising edge.
    always_ff @(posedge bclk_i) begin
        if (!rst_n_i) strobe_o <= 1'b0;
        else          strobe_o <= pulse_i;
    end

    // R5
    strobe_follow_chk: assert property (@(posedge bclk_i) disable iff (!rst_n_i)
        pulse_i |=> strobe_o);

    // R5
    strobe_single_chk: assert property (@(posedge bclk_i) disable iff (!rst_n_i)
        strobe_o |=> !strobe_o);
endmodule

// File: rtl/fsync_gen.sv
// Frame sync generator top. It passes the bit clock through as the data
// clock, divides it down, shapes a one-period frame sync, and exports a
// rising-edge frame-start strobe. Assumes a network-locked bit clock.
module fsync_gen #(
    parameter int unsigned DIV_W = fsync_pkg::DEF_DIV_W
) (
    input  logic bclk_i,
    input  logic rst_n_i,
    output logic dclk_o,
    output logic fsync_o,
    output logic frame_start_o
);
    localparam int unsigned PERIOD = 1 << DIV_W;
    localparam int unsigned GAP_W  = DIV_W + 1;

    logic sq;

    assign dclk_o = bclk_i;

    fsync_div #(.DIV_W(DIV_W)) div_i (
        .bclk_i (bclk_i),
        .rst_n_i(rst_n_i),
        .sq_o   (sq)
    );

    fsync_shaper shape_i (
        .bclk_i (bclk_i),
        .rst_n_i(rst_n_i),
        .sq_i   (sq),
        .pulse_o(fsync_o)
    );

    fsync_strobe strobe_i (
        .bclk_i  (bclk_i),
        .rst_n_i (rst_n_i),
        .pulse_i (fsync_o),
        .strobe_o(frame_start_o)
    );

    // Spacing monitor: rising edges since the last frame-start strobe.
    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    // Count edges between strobes for the spacing check.
    always_ff @(posedge bclk_i) begin
        if (!rst_n_i) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (frame_start_o) begin
            gap_q  <= GAP_W'(1);
            seen_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    // R4
    frame_gap_chk: assert property (@(posedge bclk_i) disable iff (!rst_n_i)
        (seen_q && frame_start_o) |-> gap_q == GAP_W'(PERIOD));

    // R6
    reset_quiet_chk: assert property (@(posedge bclk_i)
        !rst_n_i |=> !frame_start_o);
endmodule

// File: tb/fsync_gen_tb_top.sv
`timescale 1ns/1ps
module fsync_gen_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dclk, fs, st;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fsync_gen dut_i (
        .bclk_i       (clk),
        .rst_n_i      (rst_n),
        .dclk_o       (dclk),
        .fsync_o      (fs),
        .frame_start_o(st)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: edge count since release, and reset bookkeeping.
    int p = 0;
    bit neg_in_rst = 1'b0;
    bit pos_in_rst = 1'b0;
    int pulses = 0;

    task automatic run(input int ncyc);
        for (int i = 0; i < ncyc; i++) begin
            @(posedge clk);
            if (!rst_n) begin p = 0; pos_in_rst = 1'b1; end
            else begin p++; pos_in_rst = 1'b0; neg_in_rst = 1'b0; end
            #1;
            chk(dclk == clk, "R1", dclk, clk);
            if (!rst_n) begin
                chk(st == 1'b0, "R6", st, 0);
                if (neg_in_rst) chk(fs == 1'b0, "R6", fs, 0);
            end else begin
                // R2/R4/R5: strobe and pulse both seen high after edge 129 mod 256
                chk(st == ((p % 256) == 129), p < 256 ? "R2" : "R5", st, (p % 256) == 129);
                chk(fs == ((p % 256) == 129), "R3", fs, (p % 256) == 129);
            end
            @(negedge clk);
            if (!rst_n) neg_in_rst = 1'b1;
            #1;
            chk(dclk == clk, "R1", dclk, clk);
            if (!rst_n) begin
                chk(fs == 1'b0, "R6", fs, 0);
            end else begin
                // R4: pulse begins at the falling edge after edge 128 mod 256
                if (fs) pulses++;
                chk(fs == ((p % 256) == 128), p < 256 ? "R2" : "R4", fs, (p % 256) == 128);
                chk(st == ((p % 256) == 0 ? 1'b0 : ((p % 256) == 129)), "R5", st, (p % 256) == 129);
            end
        end
    endtask

    initial begin
        // R2: reset state
        run(4);
        chk(fs == 1'b0 && st == 1'b0, "R2", {fs, st}, 0);
        rst_n = 1'b1;
        run(1000);
        chk(pulses == 4, "R4", pulses, 4);
        // R6: reset mid-run, just as the pulse is about to start (p mod 256 == 127)
        run(127 + 256 * 4 - 1000 - 0);
        rst_n = 1'b0;
        run(5);
        rst_n = 1'b1;
        pulses = 0;
        run(600);
        chk(pulses == 2, "R6", pulses, 2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule